// File: doc/BRIEF.md
# Event Digitize and Readout Sequencer

This controller works through a backlog of first-level trigger accepts, one event at a time. For each event it asks the front-end chips to convert their stored samples, and waits for the conversion to finish. It then pulses a release so that the chip's analogue cell can be reused. Next it asks for the converted data to be shipped out, and waits for the shipment to finish. A pending-accept counter holds the backlog. A second counter tracks how many of the downstream second-level buffers are currently claimed. A buffer is claimed when a readout begins and is released by an external second-level decision.

With the chaining mode off, the sequencer goes back to idle after every event and spends one cycle there before it starts the next. With chaining on, a new conversion starts in the cycle after a readout completes, provided another accept is already waiting. In this mode the readout-busy indication also rises during conversion rather than waiting for readout. Each wait for a completion is guarded by a timeout. Counter overflow and timeouts raise sticky error flags. The block has no data stream. All handshakes are plain level requests answered by single-cycle completion pulses, and no input has back-pressure.

Top module: `readout_sequencer`

## Requirements
- R1: While `rst_n` is low, every output is 0: requests, release pulse, busy, counts and error flags.
- R2: `pend_count` rises by one for each `l1a` pulse and falls by one at each conversion start. A conversion starts (`dig_req` rises) in the cycle after the idle state sees a nonzero count.
- R3: `dig_req` stays high until a `dig_done` pulse is sampled. `l1_done` is then high for exactly the next cycle.
- R4: After conversion completes, `ro_req` rises in the next cycle if fewer than NBUF buffers are claimed. It stays high until `ro_done` is sampled.
- R5: With `early_en` low, a completed readout always returns to idle, so `dig_req` is low in the following cycle.
- R6: With `early_en` high and `pend_count` nonzero, a completed readout makes `dig_req` high in the following cycle.
- R7: `ro_busy` is high while a readout is requested or stalled. With `early_en` high it is also high while a conversion is requested.
- R8: `bufs_held` rises by one at each readout start and falls by one for each `l2_free` pulse. An `l2_free` pulse while `bufs_held` is 0 has no effect.
- R9: While `bufs_held` equals NBUF (4 by default), a completed conversion stalls with `ro_req` low until a buffer is freed.
- R10: An `l1a` that arrives while `pend_count` is at its maximum (2^PEND_W-1) and no conversion starts is dropped. `err_overflow` is then set and stays set until reset.
- R11: If a completion is missing for TIMEOUT cycles in a conversion or readout wait, the sequencer returns to idle. `err_timeout` is then set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| early_en | input | 1 | Chaining mode enable |
| l1a | input | 1 | First-level accept pulse |
| dig_done | input | 1 | Conversion complete pulse |
| ro_done | input | 1 | Readout complete pulse |
| l2_free | input | 1 | Second-level decision frees one buffer |
| dig_req | output | 1 | Conversion request (level) |
| l1_done | output | 1 | Front-end cell release pulse |
| ro_req | output | 1 | Readout request (level) |
| ro_busy | output | 1 | Readout-busy indication |
| pend_count | output | PEND_W | Waiting accepts |
| bufs_held | output | clog2(NBUF+1) | Claimed second-level buffers |
| err_overflow | output | 1 | Sticky accept overflow |
| err_timeout | output | 1 | Sticky wait timeout |

## Verification
The assertions assume that `dig_done` arrives only while `dig_req` is high, and that `ro_done` arrives only while `ro_req` is high. The bench meets this by deriving each completion from the request it observed, after a random latency shorter than the timeout. The completions are withheld entirely only in the phases that provoke timeouts and overflow. `l1a` and `l2_free` are unconstrained, so frees that arrive with no buffer claimed are part of the stimulus.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_DIG   = 2'd1,
    SQ_STALL = 2'd2,
    SQ_RO    = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rdseq_pend_ctr.sv
module rdseq_pend_ctr #(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              take,
  output logic [PEND_W-1:0] count,
  output logic              nonzero,
  output logic              overflow_err
);
  localparam logic [PEND_W-1:0] MAXV = {PEND_W{1'b1}};

  logic [PEND_W-1:0] cnt_q, cnt_d;
  logic              err_q;
  logic              drop;

  assign drop = accept && (cnt_q == MAXV) && !take;

  always_comb begin
    cnt_d = cnt_q;
    if (!drop) begin
      if (accept && !take)      cnt_d = cnt_q + 1'b1;
      else if (take && !accept) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (drop) err_q <= 1'b1;
    end
  end

  assign count        = cnt_q;
  assign nonzero      = (cnt_q != '0);
  assign overflow_err = err_q;

  // R10
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && count == MAXV && !take) |=> (overflow_err && count == MAXV));
  // R2
  pend_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (count != '0));
endmodule

// File: rtl/rdseq_l2_track.sv
module rdseq_l2_track #(
  parameter int NBUF = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       claim,
  input  logic                       release_i,
  output logic [$clog2(NBUF+1)-1:0]  held,
  output logic                       all_full
);
  localparam int HW = $clog2(NBUF+1);
  localparam logic [HW-1:0] FULLV = HW'(NBUF);

  logic [HW-1:0] held_q;
  logic          rel;

  assign rel = release_i && (held_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            held_q <= '0;
    else if (claim && !rel) held_q <= held_q + 1'b1;
    else if (rel && !claim) held_q <= held_q - 1'b1;
  end

  assign held     = held_q;
  assign all_full = (held_q == FULLV);

  // R8
  held_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held <= FULLV);
  // R9
  claim_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> (held < FULLV));
endmodule

// File: rtl/rdseq_wait_timer.sv
module rdseq_wait_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || clear)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/readout_sequencer.sv
module readout_sequencer #(
  parameter int PEND_W  = 4,
  parameter int NBUF    = 4,
  parameter int TIMEOUT = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       early_en,
  input  logic                       l1a,
  input  logic                       dig_done,
  input  logic                       ro_done,
  input  logic                       l2_free,
  output logic                       dig_req,
  output logic                       l1_done,
  output logic                       ro_req,
  output logic                       ro_busy,
  output logic [PEND_W-1:0]          pend_count,
  output logic [$clog2(NBUF+1)-1:0]  bufs_held,
  output logic                       err_overflow,
  output logic                       err_timeout
);
  import rdseq_pkg::*;

  seq_state_t state_q, state_d;
  logic take, claim, to_fire;
  logic pend_nz, all_full, expired;
  logic l1d_q, tmo_q;

  rdseq_pend_ctr #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .accept(l1a), .take(take),
    .count(pend_count), .nonzero(pend_nz), .overflow_err(err_overflow)
  );

  rdseq_l2_track #(.NBUF(NBUF)) u_l2 (
    .clk(clk), .rst_n(rst_n), .claim(claim), .release_i(l2_free),
    .held(bufs_held), .all_full(all_full)
  );

  rdseq_wait_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .run(state_q == SQ_DIG || state_q == SQ_RO),
    .clear(state_d != state_q), .expired(expired)
  );

  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    claim   = 1'b0;
    to_fire = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (pend_nz) begin
        state_d = SQ_DIG;
        take    = 1'b1;
      end
      SQ_DIG: begin
        if (dig_done) begin
          if (!all_full) begin
            state_d = SQ_RO;
            claim   = 1'b1;
          end else begin
            state_d = SQ_STALL;
          end
        end else if (expired) begin
          state_d = SQ_IDLE;
          to_fire = 1'b1;
        end
      end
      SQ_STALL: if (!all_full) begin
        state_d = SQ_RO;
        claim   = 1'b1;
      end
      SQ_RO: begin
        if (ro_done) begin
          if (early_en && pend_nz) begin
            state_d = SQ_DIG;
            take    = 1'b1;
          end else begin
            state_d = SQ_IDLE;
          end
        end else if (expired) begin
          state_d = SQ_IDLE;
          to_fire = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      l1d_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      l1d_q   <= (state_q == SQ_DIG) && dig_done;
      if (to_fire) tmo_q <= 1'b1;
    end
  end

  assign dig_req     = (state_q == SQ_DIG);
  assign ro_req      = (state_q == SQ_RO);
  assign l1_done     = l1d_q;
  assign err_timeout = tmo_q;
  assign ro_busy     = (state_q == SQ_RO) || (state_q == SQ_STALL) ||
                       (early_en && state_q == SQ_DIG);

  // R3
  l1done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_req && dig_done) |=> (l1_done && !dig_req));
  // R5
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_req && ro_done && !early_en) |=> !dig_req);
  // R6
  early_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_req && ro_done && early_en && pend_count != '0) |=> dig_req);
  // R7
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_req |-> ro_busy);
  // R11
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_req && !dig_done && expired) |=> (!dig_req && !ro_req && err_timeout));
endmodule

// File: tb/test_readout_sequencer.sv
`timescale 1ns/1ps
module test_readout_sequencer;
  localparam int PW  = 3;
  localparam int NB  = 4;
  localparam int TMO = 12;
  localparam int PMAX = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic early_en = 1'b0, l1a = 1'b0, dig_done = 1'b0, ro_done = 1'b0, l2_free = 1'b0;
  logic dig_req, l1_done, ro_req, ro_busy, err_overflow, err_timeout;
  logic [PW-1:0] pend_count;
  logic [$clog2(NB+1)-1:0] bufs_held;

  always #2.5 clk = ~clk;

  readout_sequencer #(.PEND_W(PW), .NBUF(NB), .TIMEOUT(TMO)) i_readout_sequencer (
    .clk(clk), .rst_n(rst_n), .early_en(early_en), .l1a(l1a),
    .dig_done(dig_done), .ro_done(ro_done), .l2_free(l2_free),
    .dig_req(dig_req), .l1_done(l1_done), .ro_req(ro_req), .ro_busy(ro_busy),
    .pend_count(pend_count), .bufs_held(bufs_held),
    .err_overflow(err_overflow), .err_timeout(err_timeout)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model: 0 idle, 1 converting, 2 stalled, 3 reading out
  int m_st = 0, m_prev = 0, m_pend = 0, m_held = 0, m_tmr = 0;
  int m_l1d = 0, m_eo = 0, m_et = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_prev = 0; m_pend = 0; m_held = 0; m_tmr = 0;
      m_l1d = 0; m_eo = 0; m_et = 0;
    end else begin
      int nst, dec, start, freed;
      bit tmo;
      nst = m_st; dec = 0; start = 0; tmo = 0;
      tmo = (m_tmr == TMO - 1);
      case (m_st)
        0: if (m_pend > 0) begin nst = 1; dec = 1; end
        1: if (dig_done) begin
             if (m_held < NB) begin nst = 3; start = 1; end else nst = 2;
           end else if (tmo) begin nst = 0; m_et = 1; end
        2: if (m_held < NB) begin nst = 3; start = 1; end
        default: if (ro_done) begin
             if (early_en && m_pend > 0) begin nst = 1; dec = 1; end else nst = 0;
           end else if (tmo) begin nst = 0; m_et = 1; end
      endcase
      m_l1d = (m_st == 1 && dig_done) ? 1 : 0;
      if (l1a && m_pend == PMAX && dec == 0) m_eo = 1;
      else m_pend = m_pend + (l1a ? 1 : 0) - dec;
      freed = (l2_free && m_held > 0) ? 1 : 0;
      m_held = m_held + start - freed;
      m_tmr = (nst != m_st || !(nst == 1 || nst == 3)) ? 0 : m_tmr + 1;
      m_prev = m_st;
      m_st = nst;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 dig_req", int'(dig_req), (m_st == 1) ? 1 : 0);
    chk("R2 pend_count", int'(pend_count), m_pend);
    chk("R3 l1_done", int'(l1_done), m_l1d);
    chk("R4 ro_req", int'(ro_req), (m_st == 3) ? 1 : 0);
    chk("R7 ro_busy", int'(ro_busy),
        (m_st == 3 || m_st == 2 || (early_en && m_st == 1)) ? 1 : 0);
    chk("R8 bufs_held", int'(bufs_held), m_held);
    chk("R10 err_overflow", int'(err_overflow), m_eo);
    chk("R11 err_timeout", int'(err_timeout), m_et);
    if (m_prev == 3 && m_st == 0) chk("R5 idle gap", int'(dig_req), 0);
    if (m_prev == 3 && m_st == 1) chk("R6 early chain", int'(dig_req), 1);
    if (m_st == 2) chk("R9 stall", int'(ro_req), 0);
  endtask

  task automatic run_phase(bit early, int pa, int pf, bit resp, int len);
    int dw = 0, rw = 0, dl = 1, rl = 1;
    @(negedge clk);
    rst_n = 0; l1a = 0; dig_done = 0; ro_done = 0; l2_free = 0;
    early_en = early;
    @(negedge clk);
    // R1 reset state
    chk("R1 dig_req", int'(dig_req), 0);
    chk("R1 ro_req", int'(ro_req), 0);
    chk("R1 ro_busy", int'(ro_busy), 0);
    chk("R1 counts", int'(pend_count) + int'(bufs_held), 0);
    chk("R1 errors", int'(err_overflow) + int'(err_timeout) + int'(l1_done), 0);
    rst_n = 1;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      compare_all();
      if (dig_req) dw++; else begin dw = 0; dl = $urandom_range(4); end
      if (ro_req)  rw++; else begin rw = 0; rl = $urandom_range(4); end
      dig_done = resp && dig_req && (dw > dl);
      ro_done  = resp && ro_req && (rw > rl);
      l1a      = ($urandom_range(99) < pa);
      l2_free  = ($urandom_range(99) < pf);
    end
  endtask

  initial begin
    run_phase(1'b0, 10, 30, 1'b1, 300);  // plain sequencing
    run_phase(1'b1, 30, 30, 1'b1, 400);  // chaining mode
    run_phase(1'b1, 40,  2, 1'b1, 300);  // buffers fill, stalls
    run_phase(1'b0, 20, 20, 1'b0, 150);  // no completions: timeouts
    run_phase(1'b0, 80,  0, 1'b0, 80);   // overflow of the backlog
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule